// File: doc/BRIEF.md
# Program Counter Target Generator

This block works out the next program counter value for a processor whose code space is 16 bits wide. It holds the PC in a register. Each cycle it either keeps that value, moves to a new target, or jumps to an interrupt vector. The new target is chosen by a small kind code and can be one of these:

- the sequential next-instruction address;
- a short relative branch built from a signed offset byte;
- an 11-bit in-page splice, with 3 of its bits carried in the opcode byte;
- a full 16-bit long address taken from two operand bytes;
- a computed jump from the data pointer plus the accumulator.

The decode stage supplies the address of the byte that follows the current instruction, along with the opcode, the operand bytes, A, DPTR and the branch condition result. The block also gives out a code-read address for table lookups that are based on the PC. That address is the following-instruction address plus A, and it is a pure combinational function of the inputs.

Interrupt vectors sit on a fixed 8-byte stride starting at 0003h. A vector request overrides any step in the same cycle. All address arithmetic wraps modulo 65536.

Top module: `pcgen_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes 0000h, whatever the other inputs are.
- R2: With `step` high and `kind` = 0 (sequential), or `kind` = 5, 6 or 7, `pc` becomes `next_addr`.
- R3: With `step` high, `kind` = 1 (relative) and `taken` high, `pc` becomes `next_addr` plus `opd_lo` read as a signed two's-complement byte (-128 to +127), modulo 65536.
- R4: With `step` high, `kind` = 1 and `taken` low, `pc` becomes `next_addr`. In this kind `taken` has no effect other than that.
- R5: With `step` high and `kind` = 2 (page), `pc` becomes `{next_addr[15:11], opc[7:5], opd_lo[7:0]}`. Opcode bits 7:5 land in target bits 10:8.
- R6: With `step` high and `kind` = 3 (long), `pc` becomes `{opd_hi, opd_lo}`.
- R7: With `step` high and `kind` = 4 (computed), `pc` becomes `dptr` plus the unsigned `acc`, modulo 65536.
- R8: With `vec_req` high, `pc` becomes 0003h + 8 × `vec_idx`. This takes priority over `step`.
- R9: With `step` and `vec_req` both low, `pc` holds its value.
- R10: `code_addr` equals `next_addr` plus the unsigned `acc`, modulo 65536, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Load the selected target into the PC |
| kind | input | 3 | Target kind: 0 seq, 1 rel, 2 page, 3 long, 4 computed |
| opc | input | 8 | Opcode byte (bits 7:5 used by page kind) |
| opd_lo | input | 8 | First operand byte (offset, page low byte, long low byte) |
| opd_hi | input | 8 | Second operand byte (long high byte) |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| next_addr | input | 16 | Address of the byte following the current instruction |
| taken | input | 1 | Relative branch condition result |
| vec_req | input | 1 | Interrupt vector request |
| vec_idx | input | 3 | Interrupt source index |
| pc | output | 16 | Registered program counter |
| code_addr | output | 16 | PC-based table read address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 11-bit page field and a 3-bit vector index. The 3-bit index makes all eight vector slots reachable, up to 003Bh. The 16-bit width allows the wrap corners to be driven directly:

- a negative offset from near 0000h;
- DPTR FFFFh plus a non-zero A;
- a table read past FFFFh;
- a page splice from the top 2K block, where the upper five bits must survive.

// File: rtl/pcgen_pkg.sv
// Package: shared target-kind encoding for the PC target generator.
// Assumes: kind codes above PK_COMP are treated as sequential by the top.
package pcgen_pkg;
    typedef enum logic [2:0] {
        PK_SEQ  = 3'd0,
        PK_REL  = 3'd1,
        PK_PAGE = 3'd2,
        PK_LONG = 3'd3,
        PK_COMP = 3'd4
    } pc_kind_e;
endpackage

// File: rtl/pcgen_rel.sv
// Module: pcgen_rel
// Adds a sign-extended offset byte to a base address, wrapping at the
// address width. Assumes AW > BW.
module pcgen_rel #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] off,
    output logic [AW-1:0] tgt
);
    localparam int EXT_W = AW - BW;

    logic [AW-1:0] off_ext;

    // sign-extend the offset and add it to the base
    always_comb begin
        off_ext = {{EXT_W{off[BW-1]}}, off};
        tgt     = base + off_ext;
    end
endmodule

// File: rtl/pcgen_uadd.sv
// Module: pcgen_uadd
// Adds a zero-extended byte to a full-width address, wrapping at the
// address width. Used for both the computed jump and the table read.
module pcgen_uadd #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] val,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - BW;

    // zero-extend and add
    always_comb begin
        sum = base + {{EXT_W{1'b0}}, val};
    end
endmodule

// File: rtl/pcgen_page.sv
// Module: pcgen_page
// Builds an in-page target. The top AW-PW bits come from the base
// address. The next PW-BW bits come from the top of the opcode byte,
// and the low BW bits come from the operand byte.
// Assumes BW < PW < AW and PW-BW <= BW.
module pcgen_page #(
    parameter int AW = 16,
    parameter int PW = 11,
    parameter int BW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] opc,
    input  logic [BW-1:0] lo,
    output logic [AW-1:0] tgt
);
    localparam int OB = PW - BW;

    logic [OB-1:0] op_bits;

    // take the opcode-borne bits from the top of the opcode byte
    always_comb begin
        op_bits = opc[BW-1 -: OB];
    end

    // splice the page field under the kept upper bits
    always_comb begin
        tgt = {base[AW-1:PW], op_bits, lo};
    end
endmodule

// File: rtl/pcgen_vec.sv
// Module: pcgen_vec
// Computes an interrupt vector address: VBASE plus the index shifted
// left by SLG. Assumes the result fits in AW bits.
module pcgen_vec #(
    parameter int AW    = 16,
    parameter int IW    = 3,
    parameter int VBASE = 3,
    parameter int SLG   = 3
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] vaddr
);
    localparam logic [AW-1:0] BASE_V = AW'(VBASE);
    localparam int            PAD    = AW - IW - SLG;

    logic [AW-1:0] scaled;

    // place the index at the stride position and add the base
    generate
        if (PAD > 0) begin : g_pad
            always_comb scaled = {{PAD{1'b0}}, idx, {SLG{1'b0}}};
        end else begin : g_nopad
            always_comb scaled = AW'({idx, {SLG{1'b0}}});
        end
    endgenerate

    always_comb begin
        vaddr = BASE_V + scaled;
    end
endmodule

// File: rtl/pcgen_top.sv
// Module: pcgen_top
// Holds the program counter and loads it with the target chosen by the
// kind code: sequential, relative, page splice, long or computed. A vector
// request loads a vector address instead, and reset loads zero. It also
// gives out a PC-based table read address (next_addr + acc).
// Assumes next_addr is already the address of the byte that follows the
// current instruction.
module pcgen_top
    import pcgen_pkg::*;
#(
    parameter int AW    = 16,
    parameter int BW    = 8,
    parameter int PW    = 11,
    parameter int IW    = 3,
    parameter int VBASE = 3,
    parameter int SLG   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [2:0]    kind,
    input  logic [BW-1:0] opc,
    input  logic [BW-1:0] opd_lo,
    input  logic [BW-1:0] opd_hi,
    input  logic [BW-1:0] acc,
    input  logic [AW-1:0] dptr,
    input  logic [AW-1:0] next_addr,
    input  logic          taken,
    input  logic          vec_req,
    input  logic [IW-1:0] vec_idx,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] code_addr
);
    localparam int           LONG_PAD  = AW - 2 * BW;
    localparam logic [SLG-1:0] VEC_LOW = SLG'(VBASE);

    pc_kind_e      kind_e;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] page_tgt;
    logic [AW-1:0] long_tgt;
    logic [AW-1:0] comp_tgt;
    logic [AW-1:0] vec_tgt;
    logic [AW-1:0] sel_tgt;
    logic [AW-1:0] pc_q;

    pcgen_rel #(.AW(AW), .BW(BW)) i_rel (
        .base (next_addr),
        .off  (opd_lo),
        .tgt  (rel_tgt)
    );

    pcgen_page #(.AW(AW), .PW(PW), .BW(BW)) i_page (
        .base (next_addr),
        .opc  (opc),
        .lo   (opd_lo),
        .tgt  (page_tgt)
    );

    pcgen_uadd #(.AW(AW), .BW(BW)) i_comp (
        .base (dptr),
        .val  (acc),
        .sum  (comp_tgt)
    );

    pcgen_uadd #(.AW(AW), .BW(BW)) i_tbl (
        .base (next_addr),
        .val  (acc),
        .sum  (code_addr)
    );

    pcgen_vec #(.AW(AW), .IW(IW), .VBASE(VBASE), .SLG(SLG)) i_vec (
        .idx   (vec_idx),
        .vaddr (vec_tgt)
    );

    // assemble the long target from the two operand bytes
    generate
        if (LONG_PAD > 0) begin : g_long_pad
            always_comb long_tgt = {{LONG_PAD{1'b0}}, opd_hi, opd_lo};
        end else begin : g_long_fit
            always_comb long_tgt = AW'({opd_hi, opd_lo});
        end
    endgenerate

    // choose the target for the current kind code
    always_comb begin
        kind_e = pc_kind_e'(kind);
        case (kind_e)
            PK_REL:  sel_tgt = taken ? rel_tgt : next_addr;
            PK_PAGE: sel_tgt = page_tgt;
            PK_LONG: sel_tgt = long_tgt;
            PK_COMP: sel_tgt = comp_tgt;
            default: sel_tgt = next_addr;
        endcase
    end

    // PC register: reset first, then vector, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (vec_req) begin
            pc_q <= vec_tgt;
        end else if (step) begin
            pc_q <= sel_tgt;
        end
    end

    assign pc = pc_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R9
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !vec_req) |=> $stable(pc));

    // R8
    vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> pc[SLG-1:0] == VEC_LOW);

    // R4
    rel_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !vec_req && kind == 3'd1 && !taken) |=> pc == $past(next_addr));

    // R5
    page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !vec_req && kind == 3'd2)
        |=> pc[AW-1:PW] == $past(next_addr[AW-1:PW]));

    // R6
    long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !vec_req && kind == 3'd3)
        |=> pc[2*BW-1:0] == $past({opd_hi, opd_lo}));

    // R2
    seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !vec_req && (kind == 3'd0 || kind > 3'd4))
        |=> pc == $past(next_addr));
endmodule

// File: tb/test_pcgen_top.sv
module test_pcgen_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        step;
    logic [2:0]  kind;
    logic [7:0]  opc, opd_lo, opd_hi, acc;
    logic [15:0] dptr, next_addr;
    logic        taken, vec_req;
    logic [2:0]  vec_idx;
    logic [15:0] pc, code_addr;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model_pc;

    always #2 clk = ~clk;

    pcgen_top i_pcgen_top (
        .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .opc(opc),
        .opd_lo(opd_lo), .opd_hi(opd_hi), .acc(acc), .dptr(dptr),
        .next_addr(next_addr), .taken(taken), .vec_req(vec_req),
        .vec_idx(vec_idx), .pc(pc), .code_addr(code_addr)
    );

    function automatic logic [15:0] ref_target(input logic [2:0] k, input logic [7:0] o,
        input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] a,
        input logic [15:0] dp, input logic [15:0] na, input logic tk);
        case (k)
            3'd1:    return tk ? 16'(na + {{8{lo[7]}}, lo}) : na;
            3'd2:    return {na[15:11], o[7:5], lo};
            3'd3:    return {hi, lo};
            3'd4:    return 16'(dp + {8'h00, a});
            default: return na;
        endcase
    endfunction

    function automatic logic [15:0] ref_vec(input logic [2:0] i);
        return 16'h0003 + {10'd0, i, 3'd0};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k, input logic tk);
        case (k)
            3'd1:    return tk ? "R3" : "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            default: return "R2";
        endcase
    endfunction

    // one cycle: inputs driven at the falling edge, checked at the next falling edge
    task automatic cycle(input logic r, input logic s, input logic [2:0] k,
        input logic [7:0] o, input logic [7:0] lo, input logic [7:0] hi,
        input logic [7:0] a, input logic [15:0] dp, input logic [15:0] na,
        input logic tk, input logic vr, input logic [2:0] vi);
        string tag;
        rst_n = r; step = s; kind = k; opc = o; opd_lo = lo; opd_hi = hi;
        acc = a; dptr = dp; next_addr = na; taken = tk; vec_req = vr; vec_idx = vi;
        #1;
        check("R10", code_addr, 16'(na + {8'h00, a}));
        if (!r) begin
            model_pc = 16'h0000; tag = "R1";
        end else if (vr) begin
            model_pc = ref_vec(vi); tag = "R8";
        end else if (s) begin
            model_pc = ref_target(k, o, lo, hi, a, dp, na, tk); tag = kind_tag(k, tk);
        end else begin
            tag = "R9";
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, pc, model_pc);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h5EED);
        model_pc = '0;
        @(negedge clk);
        // R1: reset wins over a vector request and a step
        cycle(1'b0, 1'b1, 3'd3, 8'h00, 8'h34, 8'h12, 8'h00, 16'h0, 16'h1000, 1'b1, 1'b1, 3'd5);
        // R3: wraps backward below zero and forward at the maximum offset
        cycle(1'b1, 1'b1, 3'd1, 8'h00, 8'h80, 8'h00, 8'h00, 16'h0, 16'h0005, 1'b1, 1'b0, 3'd0);
        cycle(1'b1, 1'b1, 3'd1, 8'h00, 8'h7F, 8'h00, 8'h00, 16'h0, 16'hFFF0, 1'b1, 1'b0, 3'd0);
        // R4: taken low ignores a non-zero offset
        cycle(1'b1, 1'b1, 3'd1, 8'h00, 8'h55, 8'h00, 8'h00, 16'h0, 16'h2222, 1'b0, 1'b0, 3'd0);
        // R5: splice in the top 2K block keeps the upper five bits
        cycle(1'b1, 1'b1, 3'd2, 8'hE1, 8'hCD, 8'h00, 8'h00, 16'h0, 16'hF812, 1'b0, 1'b0, 3'd0);
        cycle(1'b1, 1'b1, 3'd2, 8'h1F, 8'h00, 8'h00, 8'h00, 16'h0, 16'h07FF, 1'b0, 1'b0, 3'd0);
        // R6
        cycle(1'b1, 1'b1, 3'd3, 8'h00, 8'hFF, 8'hFF, 8'h00, 16'h0, 16'h0100, 1'b0, 1'b0, 3'd0);
        // R7 wrap, R10 wrap
        cycle(1'b1, 1'b1, 3'd4, 8'h00, 8'h00, 8'h00, 8'h01, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 3'd0);
        // R2: unused kind codes act as sequential
        cycle(1'b1, 1'b1, 3'd6, 8'h00, 8'h11, 8'h22, 8'h00, 16'h0, 16'h4321, 1'b1, 1'b0, 3'd0);
        // R8: vector beats step, highest index gives 003Bh
        cycle(1'b1, 1'b1, 3'd3, 8'h00, 8'h00, 8'h80, 8'h00, 16'h0, 16'h0, 1'b0, 1'b1, 3'd7);
        cycle(1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, 1'b1, 3'd0);
        // R9: hold with busy inputs
        cycle(1'b1, 1'b0, 3'd3, 8'hFF, 8'hAA, 8'hBB, 8'h99, 16'h1234, 16'h5678, 1'b1, 1'b0, 3'd2);
        for (int n = 0; n < 600; n++) begin
            logic rr, vr, ss;
            rr = ($urandom % 40) != 0;
            vr = ($urandom % 8) == 0;
            ss = ($urandom % 5) != 0;
            cycle(rr, ss, 3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  8'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), vr, 3'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule